// File: doc/BRIEF.md
# Jump Target Address Unit

This block works out where execution continues after a jump. It takes the jump form, the current code segment and the offset of the next instruction, and whatever operand the jump carries. The operand can be a relative displacement, a register value, an immediate segment:offset pair, or a pointer held in data memory. It returns the new code segment and offset, together with a single-cycle completion pulse.

Some forms take their target straight from the operands and finish one cycle after they are started. Two forms fetch their target from data memory through a byte-wide read port: the memory-indirect near jump and the memory-indirect far jump. For these the block walks consecutive byte addresses, holding each request until the memory answers. Only one read is outstanding at any time. The block reports busy until the target is assembled.

A decoder starts a jump by raising `start` with `kind` and the operands valid for one cycle. It then waits for `done` and takes `new_cs` and `new_ip` in that cycle.

Top module: `jmp_target_unit`

## Requirements
- R1: With `kind` = 0 (short relative), `new_ip` = `cur_ip` + sign-extended `disp[7:0]` modulo 2^16. `disp[15:8]` is ignored, `new_cs` = `cur_cs`, and `done` is high in the cycle after the start cycle.
- R2: With `kind` = 1 (near relative), `new_ip` = `cur_ip` + `disp` modulo 2^16, `new_cs` = `cur_cs`, and `done` is high in the cycle after the start cycle.
- R3: With `kind` = 2 (near through register), `new_ip` = `reg_val`, `new_cs` = `cur_cs`, and `done` is high in the cycle after the start cycle.
- R4: With `kind` = 4 (far immediate), `new_cs` = `imm_seg` and `new_ip` = `imm_off`, with `done` in the cycle after the start cycle.
- R5: With `kind` = 3 (near through memory), two bytes are read at pointer positions n=0 and n=1. `new_ip` = {byte1, byte0}, meaning the first byte read is the low byte. `new_cs` is the `cur_cs` captured in the start cycle.
- R6: With `kind` = 5 (far through memory), four bytes are read at n=0..3 and assigned in that order to offset low, offset high, segment low and segment high.
- R7: Read n goes to address ((`data_seg` << 4) + ((`data_off` + n) mod 2^16)) mod 2^20. `mem_req` stays high with a stable `mem_addr` until `mem_valid` is sampled high. The next byte's request may follow in the very next cycle. `mem_req` is low whenever the block is not busy.
- R8: `busy` is high from the cycle after a memory form starts until the final byte is taken. `done` is a one-cycle pulse in the cycle after the final `mem_valid`, and `busy` is low in that cycle. A `start` seen while `busy` is high is ignored.
- R9: A `start` with `kind` 6 or 7 is ignored: no `done`, no `busy`, and `new_cs`/`new_ip` are unchanged.
- R10: A synchronous reset (`rst` high at a clock edge) returns the block to idle. `done`, `busy` and `mem_req` go low, and `new_cs` and `new_ip` become zero, even in the middle of a fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a jump calculation |
| kind | input | 3 | Jump form, encoded as in R1-R6 and R9 |
| cur_cs | input | 16 | Current code segment |
| cur_ip | input | 16 | Offset of the instruction after the jump |
| disp | input | 16 | Relative displacement |
| imm_seg | input | 16 | Immediate target segment |
| imm_off | input | 16 | Immediate target offset |
| reg_val | input | 16 | Register holding the target offset |
| data_seg | input | 16 | Data segment for pointer reads |
| data_off | input | 16 | Pointer offset inside the data segment |
| mem_req | output | 1 | Byte read request |
| mem_addr | output | 20 | Byte read physical address |
| mem_valid | input | 1 | Read data valid; accepts the request |
| mem_rdata | input | 8 | Read data byte |
| busy | output | 1 | Memory fetch in progress |
| done | output | 1 | One-cycle completion pulse |
| new_cs | output | 16 | Target code segment |
| new_ip | output | 16 | Target offset |

## Verification
The operand-only forms must show `done` and the target one clock after the start edge. The bench therefore samples them at the first falling edge after that edge and checks that `done` has dropped at the next falling edge. For the memory forms the completion time is set by the memory, so the bench samples on every falling edge. It checks that `busy` is high at the first one and waits, within a bound, for the falling edge after the final accepted byte, where `done` must be high and `busy` low. The responder answers each request after a random delay of 0 to 2 cycles. This covers both back-to-back acceptance and requests held over several cycles.

// File: rtl/jtu_pkg.sv
package jtu_pkg;

  typedef enum logic [2:0] {
    JK_SHORT    = 3'd0,
    JK_NEAR     = 3'd1,
    JK_NEAR_REG = 3'd2,
    JK_NEAR_MEM = 3'd3,
    JK_FAR_IMM  = 3'd4,
    JK_FAR_MEM  = 3'd5
  } jmp_kind_e;

  typedef enum logic {
    F_IDLE  = 1'b0,
    F_FETCH = 1'b1
  } fetch_st_e;

endpackage

// File: rtl/jtu_calc.sv
module jtu_calc
  import jtu_pkg::*;
#(
  parameter int OFF_W = 16,
  parameter int SEG_W = 16,
  parameter int SHORT_W = 8
) (
  input  logic [2:0]       kind,
  input  logic [SEG_W-1:0] cur_cs,
  input  logic [OFF_W-1:0] cur_ip,
  input  logic [OFF_W-1:0] disp,
  input  logic [OFF_W-1:0] reg_val,
  input  logic [SEG_W-1:0] imm_seg,
  input  logic [OFF_W-1:0] imm_off,
  output logic             imm_hit,
  output logic             mem_hit,
  output logic             mem_far,
  output logic [SEG_W-1:0] imm_cs,
  output logic [OFF_W-1:0] imm_ip
);

  localparam int EXT_W = OFF_W - SHORT_W;

  function automatic logic [OFF_W-1:0] widen_short(input logic [OFF_W-1:0] d);
    return {{EXT_W{d[SHORT_W-1]}}, d[SHORT_W-1:0]};
  endfunction

  function automatic logic [OFF_W-1:0] rel_sum(input logic [OFF_W-1:0] base,
                                               input logic [OFF_W-1:0] delta);
    return base + delta;
  endfunction

  always_comb begin
    imm_hit = 1'b0;
    mem_hit = 1'b0;
    mem_far = 1'b0;
    imm_cs  = cur_cs;
    imm_ip  = cur_ip;
    case (kind)
      JK_SHORT: begin
        imm_hit = 1'b1;
        imm_ip  = rel_sum(cur_ip, widen_short(disp));
      end
      JK_NEAR: begin
        imm_hit = 1'b1;
        imm_ip  = rel_sum(cur_ip, disp);
      end
      JK_NEAR_REG: begin
        imm_hit = 1'b1;
        imm_ip  = reg_val;
      end
      JK_FAR_IMM: begin
        imm_hit = 1'b1;
        imm_cs  = imm_seg;
        imm_ip  = imm_off;
      end
      JK_NEAR_MEM: mem_hit = 1'b1;
      JK_FAR_MEM: begin
        mem_hit = 1'b1;
        mem_far = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/jtu_fetch.sv
module jtu_fetch
  import jtu_pkg::*;
#(
  parameter int OFF_W = 16,
  parameter int SEG_W = 16,
  parameter int SEG_SHIFT = 4,
  parameter int BYTE_W = 8,
  parameter int PA_W = SEG_W + SEG_SHIFT,
  parameter int NBYTES = (OFF_W + SEG_W) / BYTE_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     launch,
  input  logic                     launch_far,
  input  logic [SEG_W-1:0]         launch_seg,
  input  logic [OFF_W-1:0]         launch_off,
  input  logic [SEG_W-1:0]         launch_cs,
  output logic                     mem_req,
  output logic [PA_W-1:0]          mem_addr,
  input  logic                     mem_valid,
  input  logic [BYTE_W-1:0]        mem_rdata,
  output logic                     busy,
  output logic                     byte_take,
  output logic                     fin,
  output logic                     fin_far,
  output logic [SEG_W-1:0]         fin_cs,
  output logic [NBYTES*BYTE_W-1:0] fin_word
);

  localparam int IDX_W     = $clog2(NBYTES);
  localparam int NEAR_LAST = (OFF_W / BYTE_W) - 1;
  localparam int FAR_LAST  = NBYTES - 1;

  fetch_st_e        st_q;
  logic [IDX_W-1:0] idx_q;
  logic             far_q;
  logic [SEG_W-1:0] seg_q;
  logic [OFF_W-1:0] off_q;
  logic [SEG_W-1:0] cs_q;
  logic [IDX_W-1:0] last_idx;
  logic             byte_last;

  function automatic logic [PA_W-1:0] byte_addr(input logic [SEG_W-1:0] seg,
                                                input logic [OFF_W-1:0] off,
                                                input logic [IDX_W-1:0] n);
    logic [OFF_W-1:0] wrapped;
    wrapped = off + OFF_W'(n);
    return {seg, {SEG_SHIFT{1'b0}}} + PA_W'(wrapped);
  endfunction

  assign busy      = (st_q == F_FETCH);
  assign mem_req   = busy;
  assign mem_addr  = byte_addr(seg_q, off_q, idx_q);
  assign last_idx  = far_q ? IDX_W'(FAR_LAST) : IDX_W'(NEAR_LAST);
  assign byte_take = mem_req && mem_valid;
  assign byte_last = (idx_q == last_idx);
  assign fin       = byte_take && byte_last;
  assign fin_far   = far_q;
  assign fin_cs    = cs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= F_IDLE;
      idx_q <= '0;
      far_q <= 1'b0;
      seg_q <= '0;
      off_q <= '0;
      cs_q  <= '0;
    end else if (st_q == F_IDLE) begin
      if (launch) begin
        st_q  <= F_FETCH;
        idx_q <= '0;
        far_q <= launch_far;
        seg_q <= launch_seg;
        off_q <= launch_off;
        cs_q  <= launch_cs;
      end
    end else if (byte_take) begin
      if (byte_last) begin
        st_q <= F_IDLE;
      end else begin
        idx_q <= idx_q + IDX_W'(1);
      end
    end
  end

  for (genvar g = 0; g < NBYTES; g++) begin : g_lane
    logic [BYTE_W-1:0] lane_q;
    logic              lane_hit;
    assign lane_hit = byte_take && (idx_q == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (rst) begin
        lane_q <= '0;
      end else if (lane_hit) begin
        lane_q <= mem_rdata;
      end
    end
    assign fin_word[g*BYTE_W +: BYTE_W] = lane_hit ? mem_rdata : lane_q;
  end

endmodule

// File: rtl/jtu_outreg.sv
module jtu_outreg #(
  parameter int OFF_W = 16,
  parameter int SEG_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [SEG_W-1:0] load_cs,
  input  logic [OFF_W-1:0] load_ip,
  output logic             done,
  output logic [SEG_W-1:0] new_cs,
  output logic [OFF_W-1:0] new_ip
);

  always_ff @(posedge clk) begin
    if (rst) begin
      done   <= 1'b0;
      new_cs <= '0;
      new_ip <= '0;
    end else begin
      done <= load;
      if (load) begin
        new_cs <= load_cs;
        new_ip <= load_ip;
      end
    end
  end

endmodule

// File: rtl/jmp_target_unit.sv
module jmp_target_unit
  import jtu_pkg::*;
#(
  parameter int OFF_W = 16,
  parameter int SEG_W = 16,
  parameter int SEG_SHIFT = 4,
  parameter int BYTE_W = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start,
  input  logic [2:0]                 kind,
  input  logic [SEG_W-1:0]           cur_cs,
  input  logic [OFF_W-1:0]           cur_ip,
  input  logic [OFF_W-1:0]           disp,
  input  logic [SEG_W-1:0]           imm_seg,
  input  logic [OFF_W-1:0]           imm_off,
  input  logic [OFF_W-1:0]           reg_val,
  input  logic [SEG_W-1:0]           data_seg,
  input  logic [OFF_W-1:0]           data_off,
  output logic                       mem_req,
  output logic [SEG_W+SEG_SHIFT-1:0] mem_addr,
  input  logic                       mem_valid,
  input  logic [BYTE_W-1:0]          mem_rdata,
  output logic                       busy,
  output logic                       done,
  output logic [SEG_W-1:0]           new_cs,
  output logic [OFF_W-1:0]           new_ip
);

  localparam int PA_W   = SEG_W + SEG_SHIFT;
  localparam int NBYTES = (OFF_W + SEG_W) / BYTE_W;

  logic                     imm_hit, mem_hit, mem_far;
  logic [SEG_W-1:0]         imm_cs;
  logic [OFF_W-1:0]         imm_ip;
  logic                     start_taken, imm_fire, launch;
  logic                     byte_take, fetch_fire, fin_far;
  logic [SEG_W-1:0]         fin_cs;
  logic [NBYTES*BYTE_W-1:0] fin_word;
  logic                     load;
  logic [SEG_W-1:0]         load_cs;
  logic [OFF_W-1:0]         load_ip;

  assign start_taken = start && !busy;
  assign imm_fire    = start_taken && imm_hit;
  assign launch      = start_taken && mem_hit;

  jtu_calc #(.OFF_W(OFF_W), .SEG_W(SEG_W), .SHORT_W(BYTE_W)) u_calc (
    .kind    (kind),
    .cur_cs  (cur_cs),
    .cur_ip  (cur_ip),
    .disp    (disp),
    .reg_val (reg_val),
    .imm_seg (imm_seg),
    .imm_off (imm_off),
    .imm_hit (imm_hit),
    .mem_hit (mem_hit),
    .mem_far (mem_far),
    .imm_cs  (imm_cs),
    .imm_ip  (imm_ip)
  );

  jtu_fetch #(
    .OFF_W(OFF_W), .SEG_W(SEG_W), .SEG_SHIFT(SEG_SHIFT),
    .BYTE_W(BYTE_W), .PA_W(PA_W), .NBYTES(NBYTES)
  ) u_fetch (
    .clk        (clk),
    .rst        (rst),
    .launch     (launch),
    .launch_far (mem_far),
    .launch_seg (data_seg),
    .launch_off (data_off),
    .launch_cs  (cur_cs),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_valid  (mem_valid),
    .mem_rdata  (mem_rdata),
    .busy       (busy),
    .byte_take  (byte_take),
    .fin        (fetch_fire),
    .fin_far    (fin_far),
    .fin_cs     (fin_cs),
    .fin_word   (fin_word)
  );

  always_comb begin
    load    = imm_fire || fetch_fire;
    load_cs = imm_cs;
    load_ip = imm_ip;
    if (fetch_fire) begin
      load_ip = fin_word[OFF_W-1:0];
      load_cs = fin_far ? fin_word[OFF_W +: SEG_W] : fin_cs;
    end
  end

  jtu_outreg #(.OFF_W(OFF_W), .SEG_W(SEG_W)) u_out (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .load_cs (load_cs),
    .load_ip (load_ip),
    .done    (done),
    .new_cs  (new_cs),
    .new_ip  (new_ip)
  );

endmodule

// File: rtl/jtu_checker.sv
module jtu_checker #(
  parameter int OFF_W = 16,
  parameter int SEG_W = 16,
  parameter int PA_W = 20
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic [2:0]       kind,
  input logic [SEG_W-1:0] cur_cs,
  input logic [OFF_W-1:0] cur_ip,
  input logic [OFF_W-1:0] disp,
  input logic [SEG_W-1:0] imm_seg,
  input logic [OFF_W-1:0] imm_off,
  input logic [OFF_W-1:0] reg_val,
  input logic             mem_req,
  input logic [PA_W-1:0]  mem_addr,
  input logic             mem_valid,
  input logic             busy,
  input logic             done,
  input logic [SEG_W-1:0] new_cs,
  input logic [OFF_W-1:0] new_ip,
  input logic             start_taken,
  input logic             fetch_fire
);

  assert_short_target_R1: assert property (@(posedge clk) disable iff (rst)
    start_taken && kind == 3'd0 |=> done && new_cs == $past(cur_cs) &&
      new_ip == $past(cur_ip) + {{(OFF_W-8){$past(disp[7])}}, $past(disp[7:0])});

  assert_near_target_R2: assert property (@(posedge clk) disable iff (rst)
    start_taken && kind == 3'd1 |=> done && new_cs == $past(cur_cs) &&
      new_ip == $past(cur_ip) + $past(disp));

  assert_reg_target_R3: assert property (@(posedge clk) disable iff (rst)
    start_taken && kind == 3'd2 |=> done && new_cs == $past(cur_cs) && new_ip == $past(reg_val));

  assert_far_imm_R4: assert property (@(posedge clk) disable iff (rst)
    start_taken && kind == 3'd4 |=> done && new_cs == $past(imm_seg) && new_ip == $past(imm_off));

  assert_mem_launch_R5: assert property (@(posedge clk) disable iff (rst)
    start_taken && (kind == 3'd3 || kind == 3'd5) |=> busy && mem_req && !done);

  assert_req_hold_R7: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_valid |=> mem_req && $stable(mem_addr));

  assert_req_in_busy_R7: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> busy);

  assert_done_after_fetch_R8: assert property (@(posedge clk) disable iff (rst)
    fetch_fire |=> done && !busy);

  assert_no_done_when_busy_R8: assert property (@(posedge clk) disable iff (rst)
    busy |-> !done);

  assert_reserved_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    start && !busy && kind > 3'd5 |=> !done && !busy && $stable(new_ip) && $stable(new_cs));

endmodule

bind jmp_target_unit jtu_checker #(.OFF_W(OFF_W), .SEG_W(SEG_W), .PA_W(PA_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .start       (start),
  .kind        (kind),
  .cur_cs      (cur_cs),
  .cur_ip      (cur_ip),
  .disp        (disp),
  .imm_seg     (imm_seg),
  .imm_off     (imm_off),
  .reg_val     (reg_val),
  .mem_req     (mem_req),
  .mem_addr    (mem_addr),
  .mem_valid   (mem_valid),
  .busy        (busy),
  .done        (done),
  .new_cs      (new_cs),
  .new_ip      (new_ip),
  .start_taken (start_taken),
  .fetch_fire  (fetch_fire)
);

// File: tb/jmp_target_unit_tb.sv
module jmp_target_unit_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [2:0]  kind = '0;
  logic [15:0] cur_cs = '0, cur_ip = '0, disp = '0, imm_seg = '0, imm_off = '0;
  logic [15:0] reg_val = '0, data_seg = '0, data_off = '0;
  logic        mem_req;
  logic [19:0] mem_addr;
  logic        mem_valid = 1'b0;
  logic [7:0]  mem_rdata = '0;
  logic        busy, done;
  logic [15:0] new_cs, new_ip;

  int checks = 0;
  int errors = 0;
  int wait_cnt = 0;

  always #4 clk = ~clk;

  jmp_target_unit u_dut (
    .clk(clk), .rst(rst), .start(start), .kind(kind), .cur_cs(cur_cs), .cur_ip(cur_ip),
    .disp(disp), .imm_seg(imm_seg), .imm_off(imm_off), .reg_val(reg_val),
    .data_seg(data_seg), .data_off(data_off), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_valid(mem_valid), .mem_rdata(mem_rdata), .busy(busy), .done(done),
    .new_cs(new_cs), .new_ip(new_ip)
  );

  function automatic logic [7:0] mbyte(input logic [19:0] a);
    logic [19:0] h;
    h = a * 20'd37 + (a >> 7);
    return h[7:0] ^ a[15:8];
  endfunction

  function automatic logic [19:0] paddr(input logic [15:0] seg, input logic [15:0] off, input int n);
    logic [15:0] o;
    o = off + 16'(n);
    return {seg, 4'h0} + {4'h0, o};
  endfunction

  // memory responder: answers a held request after 0..2 idle cycles
  always @(negedge clk) begin
    if (mem_req && !rst) begin
      if (wait_cnt == 0) begin
        mem_valid <= 1'b1;
        mem_rdata <= mbyte(mem_addr);
        wait_cnt  <= int'($urandom % 3);
      end else begin
        mem_valid <= 1'b0;
        wait_cnt  <= wait_cnt - 1;
      end
    end else begin
      mem_valid <= 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [2:0] k);
    case (k)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R5";
      3'd4: return "R4";
      3'd5: return "R6";
      default: return "R9";
    endcase
  endfunction

  task automatic drive(input logic [2:0] k, input logic [15:0] cs, input logic [15:0] ip,
                       input logic [15:0] d, input logic [15:0] iseg, input logic [15:0] ioff,
                       input logic [15:0] rv, input logic [15:0] dseg, input logic [15:0] doff);
    start = 1'b1; kind = k; cur_cs = cs; cur_ip = ip; disp = d; imm_seg = iseg;
    imm_off = ioff; reg_val = rv; data_seg = dseg; data_off = doff;
  endtask

  task automatic run_jump(input logic [2:0] k, input logic [15:0] cs, input logic [15:0] ip,
                          input logic [15:0] d, input logic [15:0] iseg, input logic [15:0] ioff,
                          input logic [15:0] rv, input logic [15:0] dseg, input logic [15:0] doff);
    logic [15:0] ecs, eip;
    string t;
    t = tag_of(k);
    ecs = cs;
    eip = ip;
    case (k)
      3'd0: eip = ip + {{8{d[7]}}, d[7:0]};
      3'd1: eip = ip + d;
      3'd2: eip = rv;
      3'd3: eip = {mbyte(paddr(dseg, doff, 1)), mbyte(paddr(dseg, doff, 0))};
      3'd4: begin ecs = iseg; eip = ioff; end
      3'd5: begin
        eip = {mbyte(paddr(dseg, doff, 1)), mbyte(paddr(dseg, doff, 0))};
        ecs = {mbyte(paddr(dseg, doff, 3)), mbyte(paddr(dseg, doff, 2))};
      end
      default: ;
    endcase
    drive(k, cs, ip, d, iseg, ioff, rv, dseg, doff);
    @(negedge clk);
    start = 1'b0;
    if (k == 3'd3 || k == 3'd5) begin
      // R8: busy from the cycle after start
      chk(busy === 1'b1 && done === 1'b0, "R8", "busy after start", {30'd0, busy, done}, 32'd2);
      for (int i = 0; i < 40 && done !== 1'b1; i++) @(negedge clk);
      chk(done === 1'b1, "R8", "done arrives", {31'd0, done}, 32'd1);
      chk(busy === 1'b0, "R8", "idle at done", {31'd0, busy}, 32'd0);
    end else begin
      chk(done === 1'b1, t, "done one cycle after start", {31'd0, done}, 32'd1);
    end
    chk(new_ip === eip, t, "new_ip", {16'd0, new_ip}, {16'd0, eip});
    chk(new_cs === ecs, t, "new_cs", {16'd0, new_cs}, {16'd0, ecs});
    @(negedge clk);
    chk(done === 1'b0, "R8", "done is a pulse", {31'd0, done}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] keep_ip, keep_cs;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    chk(done === 1'b0 && busy === 1'b0 && mem_req === 1'b0, "R10", "idle after reset",
        {29'd0, done, busy, mem_req}, 32'd0);
    chk(new_ip === 16'd0 && new_cs === 16'd0, "R10", "targets cleared",
        {new_cs, new_ip}, 32'd0);

    // directed corners
    run_jump(3'd0, 16'h1234, 16'h0010, 16'h7F80, 0, 0, 0, 0, 0);    // R1 negative byte, high bits ignored
    run_jump(3'd0, 16'h1234, 16'hFFF0, 16'h0020, 0, 0, 0, 0, 0);    // R1 wrap upward
    run_jump(3'd1, 16'hABCD, 16'hFFF0, 16'h0020, 0, 0, 0, 0, 0);    // R2 wrap
    run_jump(3'd1, 16'hABCD, 16'h0005, 16'h8000, 0, 0, 0, 0, 0);    // R2 negative word
    run_jump(3'd2, 16'h0F00, 16'h1111, 0, 0, 0, 16'hBEEF, 0, 0);    // R3
    run_jump(3'd4, 16'h0F00, 16'h1111, 0, 16'h5000, 16'h2000, 0, 0, 0); // R4
    run_jump(3'd3, 16'h2222, 16'h3333, 0, 0, 0, 0, 16'h1000, 16'h5000); // R5
    run_jump(3'd5, 16'h2222, 16'h3333, 0, 0, 0, 0, 16'h1000, 16'h2000); // R6
    run_jump(3'd5, 16'h2222, 16'h3333, 0, 0, 0, 0, 16'h0040, 16'hFFFE); // R7 offset wraps in segment
    run_jump(3'd5, 16'h2222, 16'h3333, 0, 0, 0, 0, 16'hFFFF, 16'h0020); // R7 physical wrap

    // R9 reserved kinds ignored
    keep_ip = new_ip;
    keep_cs = new_cs;
    for (int r = 6; r < 8; r++) begin
      drive(3'(r), 16'h9999, 16'h8888, 16'h0101, 16'h7777, 16'h6666, 16'h5555, 16'h4444, 16'h3333);
      @(negedge clk);
      start = 1'b0;
      chk(done === 1'b0 && busy === 1'b0, "R9", "reserved kind no activity",
          {30'd0, done, busy}, 32'd0);
      chk(new_ip === keep_ip && new_cs === keep_cs, "R9", "targets unchanged",
          {new_cs, new_ip}, {keep_cs, keep_ip});
    end

    // R8 start while busy is ignored
    drive(3'd5, 16'h1000, 16'h2000, 0, 0, 0, 0, 16'h0300, 16'h0400);
    @(negedge clk);
    drive(3'd4, 16'h1000, 16'h2000, 0, 16'hDEAD, 16'hF00D, 0, 0, 0);
    repeat (2) @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 40 && done !== 1'b1; i++) @(negedge clk);
    chk(new_ip === {mbyte(paddr(16'h0300, 16'h0400, 1)), mbyte(paddr(16'h0300, 16'h0400, 0))} &&
        new_cs === {mbyte(paddr(16'h0300, 16'h0400, 3)), mbyte(paddr(16'h0300, 16'h0400, 2))},
        "R8", "start while busy ignored", {new_cs, new_ip},
        {mbyte(paddr(16'h0300, 16'h0400, 3)), mbyte(paddr(16'h0300, 16'h0400, 2)),
         mbyte(paddr(16'h0300, 16'h0400, 1)), mbyte(paddr(16'h0300, 16'h0400, 0))});
    @(negedge clk);
    chk(done === 1'b0 && busy === 1'b0, "R8", "no extra completion", {30'd0, done, busy}, 32'd0);

    // R10 reset in the middle of a fetch
    drive(3'd5, 16'h1000, 16'h2000, 0, 0, 0, 0, 16'h0500, 16'h0600);
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(busy === 1'b0 && mem_req === 1'b0 && done === 1'b0, "R10", "reset aborts fetch",
        {29'd0, busy, mem_req, done}, 32'd0);
    chk(new_ip === 16'd0 && new_cs === 16'd0, "R10", "reset clears targets", {new_cs, new_ip}, 32'd0);
    repeat (2) @(negedge clk);

    // constrained random mix
    for (int n = 0; n < 300; n++) begin
      run_jump(3'($urandom % 6), 16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom),
               16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule